// File: doc/BRIEF.md
# OSD Frame Control and Blink Unit

This block is the control register bank of an on-screen display engine. A host, usually through a serial-bus slave front end, writes and reads bytes over a simple address/data port. Three control bytes live at 8400h, 8401h and 8402h. From them the unit derives the gated window enables, the active line length in pixels, the font plane select and the transparency rule for palette lookups.

The unit also owns the write port of the display page RAM. A self-clearing command bit starts a sequencer that writes zero to every page entry, one entry per clock, while the host is locked out of the page. Host accesses to the page window at 8000h–81FFh are steered to the character or the attribute plane by a select bit. A field counter advanced by vertical sync produces the blink phase.

Top module: `osd_frame_ctrl`

## Requirements
- R1: After reset all three control registers read zero and the blink output is 1. Reserved bits and unmapped addresses read zero. Readback layout: 8400h = {3'b0, transp_dis[4], clear_busy[3], win2[2], win1[1], osd_en[0]}, 8401h = full byte, 8402h = {6'b0, attr_sel[1], plane_sel[0]}.
- R2: win1_en is 8400h bit0 AND bit1, and win2_en is bit0 AND bit2.
- R3: Writing 1 to bit 3 of 8400h starts a clear that writes zero to both planes of every page entry, in ascending order, one entry per clock. clear_busy and bit 3 read 1 for exactly PAGE_DEPTH cycles and then return to 0 by themselves.
- R4: During a clear, host writes to the page window are ignored and a second clear command does not restart the sequence.
- R5: px_transparent is 1 only when pal_color is zero, pal_addr is below 8 and 8400h bit 4 is 0. Palette addresses 8 and above are never transparent.
- R6: While 8401h bits 4:0 are zero, blink_on is held at 1 and the field count is reset.
- R7: With a non-zero period P in 8401h bits 4:0, blink_on toggles on every 8·P-th vsync rising edge and stays stable otherwise.
- R8: line_pixels equals 512 + 64 × (8401h bits 7:5).
- R9: font_plane follows 8402h bit 0.
- R10: Host reads of 8000h–81FFh return the character code when 8402h bit 1 is 0 and the attribute code when it is 1. Host writes in that window go to the plane selected by the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| ram_addr | output | AW | Page RAM address |
| ram_we_char | output | 1 | Character plane write enable |
| ram_we_attr | output | 1 | Attribute plane write enable |
| ram_wdata | output | CODE_W | Page RAM write data |
| ram_rd_char | input | CODE_W | Character code read from the page RAM |
| ram_rd_attr | input | CODE_W | Attribute code read from the page RAM |
| vsync | input | 1 | Vertical sync, synchronous to clk |
| pal_addr | input | 4 | Palette address of the current pixel |
| pal_color | input | 9 | Palette color of the current pixel |
| px_transparent | output | 1 | Pixel is transparent |
| win1_en | output | 1 | Window 1 active |
| win2_en | output | 1 | Window 2 active |
| blink_on | output | 1 | Blink phase, 1 = visible |
| line_pixels | output | 10 | Active pixels per line |
| font_plane | output | 1 | Four-color pixel bit selected for font access |
| clear_busy | output | 1 | Page clear in progress |

## Verification
The bench builds the unit with PAGE_DEPTH = 32 and keeps the blink multiplier at 8. With the smaller page, every entry in both planes can be read back before and after a clear, and the exact clear duration can be counted cycle by cycle. A host write and a repeated clear command can also be placed in the middle of the sequence. The unchanged multiplier keeps blink toggle points at multiples of eight fields, so periods 1 and 2 are checked pulse by pulse.

// File: rtl/osd_frame_pkg.sv
package osd_frame_pkg;

    localparam logic [15:0] CTRL1_ADDR = 16'h8400;
    localparam logic [15:0] CTRL2_ADDR = 16'h8401;
    localparam logic [15:0] FONT_ADDR  = 16'h8402;
    localparam logic [6:0]  PAGE_TAG   = 7'h40;   // host_addr[15:9] of 8000h-81FFh

    typedef struct packed {
        logic       osd_en;
        logic       win1;
        logic       win2;
        logic       transp_dis;
        logic [7:0] ctrl2;
        logic       plane_sel;
        logic       attr_sel;
    } osd_cfg_t;

endpackage

// File: rtl/osd_ctrl_regs.sv
module osd_ctrl_regs
    import osd_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        clear_busy,
    output osd_cfg_t    cfg,
    output logic        clear_start
);

    osd_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d       = cfg_q;
        clear_start = 1'b0;
        if (wr_en) begin
            unique case (addr)
                CTRL1_ADDR: begin
                    cfg_d.osd_en     = wdata[0];
                    cfg_d.win1       = wdata[1];
                    cfg_d.win2       = wdata[2];
                    cfg_d.transp_dis = wdata[4];
                    clear_start      = wdata[3] & ~clear_busy;
                end
                CTRL2_ADDR: cfg_d.ctrl2 = wdata;
                FONT_ADDR: begin
                    cfg_d.plane_sel = wdata[0];
                    cfg_d.attr_sel  = wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/osd_clear_seq.sv
module osd_clear_seq #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [AW-1:0] idx
);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] idx;
    } clr_state_t;

    clr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == AW'(DEPTH - 1)) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign idx  = st_q.idx;

endmodule

// File: rtl/osd_blink_gen.sv
module osd_blink_gen #(
    parameter int PER_W      = 5,
    parameter int FIELD_MULT = 8,
    localparam int CNT_W     = PER_W + $clog2(FIELD_MULT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    input  logic [PER_W-1:0] period,
    output logic             vs_rise,
    output logic             blink_on
);

    typedef struct packed {
        logic             vs;
        logic             phase;
        logic [CNT_W-1:0] cnt;
    } blink_state_t;

    blink_state_t     st_d, st_q;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_inc;

    assign vs_rise = vsync & ~st_q.vs;
    assign target  = CNT_W'(period) * CNT_W'(FIELD_MULT);
    assign cnt_inc = st_q.cnt + 1'b1;

    always_comb begin
        st_d    = st_q;
        st_d.vs = vsync;
        if (period == '0) begin
            st_d.phase = 1'b1;
            st_d.cnt   = '0;
        end else if (vs_rise) begin
            if (cnt_inc >= target) begin
                st_d.cnt   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{vs: 1'b0, phase: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign blink_on = st_q.phase;

endmodule

// File: rtl/osd_frame_ctrl.sv
module osd_frame_ctrl
    import osd_frame_pkg::*;
#(
    parameter int PAGE_DEPTH = 512,
    parameter int CODE_W     = 8,
    parameter int BLINK_MULT = 8,
    localparam int AW        = $clog2(PAGE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [15:0]       host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [AW-1:0]     ram_addr,
    output logic              ram_we_char,
    output logic              ram_we_attr,
    output logic [CODE_W-1:0] ram_wdata,
    input  logic [CODE_W-1:0] ram_rd_char,
    input  logic [CODE_W-1:0] ram_rd_attr,
    input  logic              vsync,
    input  logic [3:0]        pal_addr,
    input  logic [8:0]        pal_color,
    output logic              px_transparent,
    output logic              win1_en,
    output logic              win2_en,
    output logic              blink_on,
    output logic [9:0]        line_pixels,
    output logic              font_plane,
    output logic              clear_busy
);

    osd_cfg_t      cfg;
    logic          clear_start;
    logic [AW-1:0] clr_idx;
    logic          vs_rise;
    logic          page_hit;

    osd_ctrl_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (host_wr),
        .addr        (host_addr),
        .wdata       (host_wdata),
        .clear_busy  (clear_busy),
        .cfg         (cfg),
        .clear_start (clear_start)
    );

    osd_clear_seq #(.DEPTH(PAGE_DEPTH)) u_clear (
        .clk   (clk),
        .rst_n (rst_n),
        .start (clear_start),
        .busy  (clear_busy),
        .idx   (clr_idx)
    );

    osd_blink_gen #(.PER_W(5), .FIELD_MULT(BLINK_MULT)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .vsync    (vsync),
        .period   (cfg.ctrl2[4:0]),
        .vs_rise  (vs_rise),
        .blink_on (blink_on)
    );

    assign page_hit    = (host_addr[15:9] == PAGE_TAG);
    assign win1_en     = cfg.osd_en & cfg.win1;
    assign win2_en     = cfg.osd_en & cfg.win2;
    assign line_pixels = 10'd512 + {1'b0, cfg.ctrl2[7:5], 6'b0};
    assign font_plane  = cfg.plane_sel;

    // Only black in the lower eight palette slots may become transparent
    assign px_transparent = ~cfg.transp_dis & ~pal_addr[3] & (pal_color == 9'd0);

    // Page RAM port: sequencer owns it while clearing, host otherwise
    always_comb begin
        if (clear_busy) begin
            ram_addr    = clr_idx;
            ram_we_char = 1'b1;
            ram_we_attr = 1'b1;
            ram_wdata   = '0;
        end else begin
            ram_addr    = host_addr[AW-1:0];
            ram_we_char = host_wr & page_hit & ~cfg.attr_sel;
            ram_we_attr = host_wr & page_hit &  cfg.attr_sel;
            ram_wdata   = CODE_W'(host_wdata);
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        if (page_hit) begin
            host_rdata = cfg.attr_sel ? 8'(ram_rd_attr) : 8'(ram_rd_char);
        end else begin
            unique case (host_addr)
                CTRL1_ADDR: host_rdata = {3'b000, cfg.transp_dis, clear_busy,
                                          cfg.win2, cfg.win1, cfg.osd_en};
                CTRL2_ADDR: host_rdata = cfg.ctrl2;
                FONT_ADDR:  host_rdata = {6'b0, cfg.attr_sel, cfg.plane_sel};
                default:    host_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/osd_frame_ctrl_chk.sv
module osd_frame_ctrl_chk #(
    parameter int PAGE_DEPTH = 512,
    parameter int CODE_W     = 8,
    localparam int AW        = $clog2(PAGE_DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win1_en,
    input logic              win2_en,
    input logic              osd_en,
    input logic              clear_busy,
    input logic [AW-1:0]     ram_addr,
    input logic              ram_we_char,
    input logic              ram_we_attr,
    input logic [CODE_W-1:0] ram_wdata,
    input logic              px_transparent,
    input logic [3:0]        pal_addr,
    input logic              blink_on,
    input logic [4:0]        blink_per,
    input logic              vs_rise
);

    p_win_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win1_en || win2_en) |-> osd_en);

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_busy |-> (ram_we_char && ram_we_attr && ram_wdata == '0));

    p_clear_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_busy && $past(clear_busy)) |-> (ram_addr == AW'($past(ram_addr) + 1'b1)));

    p_clear_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clear_busy) |-> ($past(ram_addr) == AW'(PAGE_DEPTH - 1)));

    p_upper_opaque_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pal_addr[3] |-> !px_transparent);

    p_blink_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_per == 5'd0) |=> blink_on);

    p_blink_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_rise && blink_per != 5'd0) |=> $stable(blink_on));

endmodule

bind osd_frame_ctrl osd_frame_ctrl_chk #(.PAGE_DEPTH(PAGE_DEPTH), .CODE_W(CODE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .win1_en        (win1_en),
    .win2_en        (win2_en),
    .osd_en         (cfg.osd_en),
    .clear_busy     (clear_busy),
    .ram_addr       (ram_addr),
    .ram_we_char    (ram_we_char),
    .ram_we_attr    (ram_we_attr),
    .ram_wdata      (ram_wdata),
    .px_transparent (px_transparent),
    .pal_addr       (pal_addr),
    .blink_on       (blink_on),
    .blink_per      (cfg.ctrl2[4:0]),
    .vs_rise        (vs_rise)
);

// File: tb/tb_osd_frame_ctrl.sv
`timescale 1ns/1ps
module tb_osd_frame_ctrl;

    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [15:0]   host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_we_char, ram_we_attr;
    logic [7:0]    ram_wdata, ram_rd_char, ram_rd_attr;
    logic          vsync = 1'b0;
    logic [3:0]    pal_addr = '0;
    logic [8:0]    pal_color = '0;
    logic          px_transparent, win1_en, win2_en, blink_on, font_plane, clear_busy;
    logic [9:0]    line_pixels;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] mem_c [DEPTH];
    logic [7:0] mem_a [DEPTH];
    logic [7:0] exp_c [DEPTH];
    logic [7:0] exp_a [DEPTH];

    always #5 clk = ~clk;

    osd_frame_ctrl #(.PAGE_DEPTH(DEPTH), .CODE_W(8), .BLINK_MULT(8)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ram_addr(ram_addr),
        .ram_we_char(ram_we_char), .ram_we_attr(ram_we_attr), .ram_wdata(ram_wdata),
        .ram_rd_char(ram_rd_char), .ram_rd_attr(ram_rd_attr), .vsync(vsync),
        .pal_addr(pal_addr), .pal_color(pal_color), .px_transparent(px_transparent),
        .win1_en(win1_en), .win2_en(win2_en), .blink_on(blink_on),
        .line_pixels(line_pixels), .font_plane(font_plane), .clear_busy(clear_busy)
    );

    // Behavioural page RAM attached to the write port
    always @(posedge clk) begin
        if (ram_we_char) mem_c[ram_addr] <= ram_wdata;
        if (ram_we_attr) mem_a[ram_addr] <= ram_wdata;
    end
    assign ram_rd_char = mem_c[ram_addr];
    assign ram_rd_attr = mem_a[ram_addr];

    function automatic logic exp_transp(logic td, logic [3:0] pa, logic [8:0] pc);
        return !td && pa < 4'd8 && pc == 9'd0;
    endfunction

    function automatic logic [9:0] exp_pixels(logic [2:0] code);
        return 10'(512 + 64 * int'(code));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic vs_pulse();
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r, v1, v2, v3;
        logic       td, exp_bl;
        int         cyc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            mem_c[i] = 8'hA5; mem_a[i] = 8'h5A;
            exp_c[i] = 8'hA5; exp_a[i] = 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(16'h8400, r); check("R1 reset ctrl1", r, 8'h00);
        rd(16'h8401, r); check("R1 reset ctrl2", r, 8'h00);
        rd(16'h8402, r); check("R1 reset font", r, 8'h00);
        check("R1 reset blink", blink_on, 1'b1);
        check("R2 reset win1", win1_en, 1'b0);
        check("R8 reset pixels", line_pixels, 10'd512);

        // Random register traffic (R1 R2 R8 R9)
        for (int i = 0; i < 40; i++) begin
            v1 = 8'($urandom) & 8'hF7;
            v2 = 8'($urandom);
            v3 = 8'($urandom);
            wr(16'h8400, v1);
            wr(16'h8401, v2);
            wr(16'h8402, v3);
            wr(16'h8403 + 16'($urandom % 8), 8'($urandom));
            rd(16'h8400, r); check("R1 ctrl1 readback", r, v1 & 8'h17);
            rd(16'h8401, r); check("R1 ctrl2 readback", r, v2);
            rd(16'h8402, r); check("R1 font readback", r, v3 & 8'h03);
            rd(16'h8403, r); check("R1 unmapped read", r, 8'h00);
            check("R2 win1", win1_en, v1[0] & v1[1]);
            check("R2 win2", win2_en, v1[0] & v1[2]);
            check("R8 pixels", line_pixels, exp_pixels(v2[7:5]));
            check("R9 font plane", font_plane, v3[0]);
        end
        wr(16'h8401, 8'hE0);
        check("R8 pixels max", line_pixels, 10'd960);

        // R10: page writes and steered reads
        for (int i = 0; i < 48; i++) begin
            int idx;
            idx = int'($urandom % DEPTH);
            v3 = 8'($urandom);
            v1 = 8'($urandom);
            wr(16'h8402, {6'b0, v3[1], 1'b0});
            wr(16'h8000 + 16'(idx), v1);
            if (v3[1]) exp_a[idx] = v1; else exp_c[idx] = v1;
        end
        wr(16'h8402, 8'h00);
        for (int i = 0; i < DEPTH; i++) begin
            rd(16'h8000 + 16'(i), r); check("R10 char read", r, exp_c[i]);
        end
        wr(16'h8402, 8'h02);
        for (int i = 0; i < DEPTH; i++) begin
            rd(16'h8000 + 16'(i), r); check("R10 attr read", r, exp_a[i]);
        end
        wr(16'h8402, 8'h00);
        wr(16'h8000, 8'h3C); exp_c[0] = 8'h3C;

        // R3 R4: clear with host intrusion and repeated command
        wr(16'h8400, 8'h09);
        rd(16'h8400, r); check("R3 busy bit reads one", r, 8'h09);
        cyc = 0;
        while (clear_busy && cyc < 4 * DEPTH) begin
            cyc++;
            if (cyc == 3) begin
                host_wr = 1'b1; host_addr = 16'h8000; host_wdata = 8'h77;
            end else if (cyc == 5) begin
                host_wr = 1'b1; host_addr = 16'h8400; host_wdata = 8'h09;
            end else begin
                host_wr = 1'b0;
            end
            @(negedge clk);
        end
        host_wr = 1'b0;
        check("R3 R4 clear duration", cyc, DEPTH);
        rd(16'h8400, r); check("R3 busy self clears", r, 8'h01);
        for (int i = 0; i < DEPTH; i++) begin
            rd(16'h8000 + 16'(i), r); check("R3 R4 char cleared", r, 8'h00);
        end
        wr(16'h8402, 8'h02);
        for (int i = 0; i < DEPTH; i++) begin
            rd(16'h8000 + 16'(i), r); check("R3 attr cleared", r, 8'h00);
        end

        // R5: transparency, directed corners then random
        wr(16'h8400, 8'h01);
        pal_addr = 4'd7; pal_color = 9'd0; #1;
        check("R5 slot7 black", px_transparent, 1'b1);
        pal_addr = 4'd8; #1;
        check("R5 slot8 black", px_transparent, 1'b0);
        pal_addr = 4'd0; pal_color = 9'd1; #1;
        check("R5 non-black", px_transparent, 1'b0);
        for (int i = 0; i < 30; i++) begin
            td = 1'($urandom);
            wr(16'h8400, {3'b0, td, 4'b0001});
            pal_addr = 4'($urandom);
            pal_color = ($urandom % 3 == 0) ? 9'd0 : 9'($urandom);
            #1;
            check("R5 transparency", px_transparent, exp_transp(td, pal_addr, pal_color));
        end

        // R6: zero period holds visible
        wr(16'h8401, 8'h00);
        for (int i = 0; i < 10; i++) begin
            vs_pulse();
            check("R6 hold visible", blink_on, 1'b1);
        end

        // R7: toggle every 8*P fields
        exp_bl = 1'b1;
        for (int p = 1; p <= 2; p++) begin
            wr(16'h8401, 8'(p));
            for (int k = 1; k <= 16 * p; k++) begin
                vs_pulse();
                if (k % (8 * p) == 0) exp_bl = ~exp_bl;
                check("R7 blink phase", blink_on, exp_bl);
            end
        end
        repeat (5) @(negedge clk);
        check("R7 stable without vsync", blink_on, exp_bl);

        finish_run();
    end

endmodule